// File: doc/BRIEF.md
# Two-Pin GPIO Port with Boot Strap and Wake Interrupt

This block is a small general-purpose port with two pins, addressed by software through register bits 0 and 2. Pin 0 is a boot-mode strap. While reset is held low, its input buffer and pull-up are on, so an external level can be sensed. The level present at the last clock of reset is latched and held as the boot-mode output. After reset, pin 0 works as a plain output. Pin 2 is a general-purpose I/O whose input also serves as an external interrupt. The interrupt can wake the chip from its low-power stop state.

Software reaches the block through a simple word-addressed register bus. Writes land on a clock edge and reads are combinational. There are four registers: output data, output enable, pin-2 function select and pin-2 input enable. The clock and mode controller supplies two level flags. One says the chip is in stop mode. The other says pin driving must cease during stop. The block turns the register state and these flags into the pad controls and the interrupt request.

Top module: `gpio_strap_port`

## Requirements
- R1: In the data and enable registers only bits 0 and 2 exist. In the function and input-enable registers only bit 2 exists. Every other bit reads 0 and ignores writes.
- R2: While rst_n is low, pad_ie[0] and pad_pu[0] are both 1.
- R3: boot_mode takes the value of pad_in[0] at the last rising clock edge with rst_n low, and then holds until the next reset, whatever pad_in[0] does. A value of 1 means boot from on-chip flash; 0 means single-boot from the internal program.
- R4: After reset, all four registers read 0, pad_oe is 0, pad_out is 0, pad_ie is 0 and pad_pu is 2'b01.
- R5: Bit 0 of the enable register drives pad_oe[0] and bit 2 drives pad_oe[1]. Bits 0 and 2 of the data register drive pad_out[0] and pad_out[1]. A 1 enables the output.
- R6: pad_in[1] passes through a two-flop synchronizer. With input enabled, data-register bit 2 reads the synchronized pin two clock edges after a change. With input disabled, it reads the output latch.
- R7: Outside stop mode, irq_out equals the synchronized pin-2 level whenever the input-enable bit (bit 2) is 1, whatever the function bit holds. It is 0 when that input is disabled.
- R8: In stop mode, irq_out is asserted only when the function register bit 2 is 1 (interrupt) and input is enabled. This holds even when stop_drive is 1.
- R9: When stop_mode and stop_drive are both 1 and function bit 2 is 0, pad_oe is forced to 2'b00. When function bit 2 is 1, pad_oe follows the enable register.
- R10: The register byte offsets are: data 0x00, output enable 0x04, function 0x08, input enable 0x0C. Any other offset reads 0 and accepts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; its release latches the strap |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write on this clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| pad_in | input | 2 | Pad levels: [0] pin 0, [1] pin 2 |
| pad_out | output | 2 | Output data to the pads |
| pad_oe | output | 2 | Output enables to the pads |
| pad_ie | output | 2 | Input buffer enables to the pads |
| pad_pu | output | 2 | Pull-up enables to the pads |
| stop_mode | input | 1 | Chip is in low-power stop |
| stop_drive | input | 1 | Pin driving is to cease during stop |
| boot_mode | output | 1 | Latched strap: 1 flash boot, 0 single boot |
| irq_out | output | 1 | Pin-2 interrupt request (level) |

## Verification
The bench builds the block with ADDR_W = 5, DATA_W = 32 and SYNC_STAGES = 2. The 5-bit address exposes an unmapped word at 0x10, so the read-as-zero and ignored-write behaviour can be checked. The full 32-bit data path lets all-ones writes show which bits are implemented. The two-stage synchronizer makes the two-edge delay of the pin-2 read-back observable. The bench applies two resets with opposite strap levels, so both boot modes are latched. It toggles the pin after each release to confirm the latched value holds.

// File: rtl/gpio_strap_pkg.sv
// Shared constants and types for the two-pin strap/wake port.
// Assumes pin index 0 maps to register bit 0 and pin index 1 to bit 2.
package gpio_strap_pkg;
    localparam int BIT_P0 = 0;
    localparam int BIT_P2 = 2;
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_OUTEN = 8'h04;
    localparam logic [7:0] OFS_FUNC = 8'h08;
    localparam logic [7:0] OFS_INEN = 8'h0C;

    typedef struct packed {
        logic [1:0] dat;     // output latch, [0]=pin0 [1]=pin2
        logic [1:0] outen;   // output enable per pin
        logic       fn2;     // pin 2: 1 interrupt, 0 port
        logic       inen2;   // pin 2 input enable
    } port_regs_t;
endpackage

// File: rtl/gpio_strap_regs.sv
// Register file: holds the data, output-enable, function and input-enable
// state. Writes take effect on the clock edge; reads are combinational.
// Assumes bus_addr is a byte address compared in full.
module gpio_strap_regs
    import gpio_strap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pin2_sync,
    output port_regs_t        regs,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_OUTEN = ADDR_W'(OFS_OUTEN);
    localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(OFS_FUNC);
    localparam logic [ADDR_W-1:0] A_INEN = ADDR_W'(OFS_INEN);

    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    // Register update: reset clears everything, writes touch implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_DATA) begin
                regs.dat <= {bus_wdata[BIT_P2], bus_wdata[BIT_P0]};
            end
            if (bus_addr == A_OUTEN) begin
                regs.outen <= {bus_wdata[BIT_P2], bus_wdata[BIT_P0]};
            end
            if (bus_addr == A_FUNC) begin
                regs.fn2 <= bus_wdata[BIT_P2];
            end
            if (bus_addr == A_INEN) begin
                regs.inen2 <= bus_wdata[BIT_P2];
            end
        end
    end

    // Read mux: pin 2 data reads the synchronized pad when input is enabled.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_DATA) begin
            bus_rdata[BIT_P0] = regs.dat[0];
            bus_rdata[BIT_P2] = regs.inen2 ? pin2_sync : regs.dat[1];
        end else if (bus_addr == A_OUTEN) begin
            bus_rdata[BIT_P0] = regs.outen[0];
            bus_rdata[BIT_P2] = regs.outen[1];
        end else if (bus_addr == A_FUNC) begin
            bus_rdata[BIT_P2] = regs.fn2;
        end else if (bus_addr == A_INEN) begin
            bus_rdata[BIT_P2] = regs.inen2;
        end
    end
endmodule

// File: rtl/gpio_strap_sync.sv
// Multi-flop synchronizer for an asynchronous pad input.
// Assumes STAGES >= 2; the chain clears to 0 in reset.
module gpio_strap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pad level through the chain once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_strap_latch.sv
// Boot strap capture: tracks the pin while reset is low and holds the
// final value once reset is released.
// Assumes the strap level is stable for at least one clock before release.
module gpio_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic boot_mode
);
    // Follow the strap during reset, freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_mode <= strap_in;
    end
endmodule

// File: rtl/gpio_strap_pinctl.sv
// Pad control and interrupt gating. Purely combinational.
// Assumes stop_mode/stop_drive are already synchronous to clk.
module gpio_strap_pinctl
    import gpio_strap_pkg::*;
(
    input  logic       rst_n,
    input  port_regs_t regs,
    input  logic       pin2_sync,
    input  logic       stop_mode,
    input  logic       stop_drive,
    output logic [1:0] pad_out,
    output logic [1:0] pad_oe,
    output logic [1:0] pad_ie,
    output logic [1:0] pad_pu,
    output logic       irq_out
);
    logic drive_off;

    // Drive-off applies only in stop with driving halted and no wake function.
    always_comb begin
        drive_off = stop_mode && stop_drive && !regs.fn2;
        pad_out   = regs.dat;
        pad_oe    = drive_off ? 2'b00 : regs.outen;
        pad_ie    = {regs.inen2, !rst_n};
        pad_pu    = 2'b01;
        irq_out   = regs.inen2 && pin2_sync && (!stop_mode || regs.fn2);
    end
endmodule

// File: rtl/gpio_strap_port.sv
// Top of the two-pin strap/wake port: register file, pin-2 synchronizer,
// strap latch and pad/interrupt control.
// Assumes a single clock domain with synchronous active-low reset.
module gpio_strap_port
    import gpio_strap_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        pad_in,
    output logic [1:0]        pad_out,
    output logic [1:0]        pad_oe,
    output logic [1:0]        pad_ie,
    output logic [1:0]        pad_pu,
    input  logic              stop_mode,
    input  logic              stop_drive,
    output logic              boot_mode,
    output logic              irq_out
);
    port_regs_t regs;
    logic       pin2_sync;

    gpio_strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in[1]), .q(pin2_sync)
    );

    gpio_strap_latch u_latch (
        .clk(clk), .rst_n(rst_n), .strap_in(pad_in[0]), .boot_mode(boot_mode)
    );

    gpio_strap_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin2_sync(pin2_sync),
        .regs(regs), .bus_rdata(bus_rdata)
    );

    gpio_strap_pinctl u_pinctl (
        .rst_n(rst_n), .regs(regs), .pin2_sync(pin2_sync),
        .stop_mode(stop_mode), .stop_drive(stop_drive),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .irq_out(irq_out)
    );
endmodule

// File: rtl/gpio_strap_port_chk.sv
// Assertion checker for gpio_strap_port, attached by bind below.
module gpio_strap_port_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        pad_oe,
    input logic [1:0]        pad_ie,
    input logic [1:0]        pad_pu,
    input logic              stop_mode,
    input logic              stop_drive,
    input logic              boot_mode,
    input logic              irq_out,
    input logic              fn2,
    input logic              inen2
);
    localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(5);

    assert_rdata_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == '0);

    assert_strap_pads_in_reset_R2: assert property (@(posedge clk)
        !rst_n |-> (pad_ie[0] && pad_pu[0]));

    assert_boot_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_mode));

    assert_reset_defaults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == 2'b00 && !pad_ie[1]));

    assert_stop_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (inen2 && (!stop_mode || fn2)));

    assert_stop_drive_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && stop_drive && !fn2) |-> (pad_oe == 2'b00));
endmodule

bind gpio_strap_port gpio_strap_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_pu(pad_pu), .stop_mode(stop_mode),
    .stop_drive(stop_drive), .boot_mode(boot_mode), .irq_out(irq_out),
    .fn2(regs.fn2), .inen2(regs.inen2)
);

// File: tb/gpio_strap_port_tb_top.sv
// Self-checking bench for gpio_strap_port.
module gpio_strap_port_tb_top;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [1:0]        pad_in = 2'b00;
    logic [1:0]        pad_out, pad_oe, pad_ie, pad_pu;
    logic              stop_mode = 1'b0;
    logic              stop_drive = 1'b0;
    logic              boot_mode, irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_strap_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .stop_mode(stop_mode), .stop_drive(stop_drive),
        .boot_mode(boot_mode), .irq_out(irq_out)
    );

    // Vector: {addr[4:0], wdata[31:0], expected read[31:0]}
    localparam logic [68:0] VEC [0:7] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h0000_0005},  // R1 R10 data
        {5'h04, 32'hFFFF_FFFA, 32'h0000_0000},  // R1 R10 enable, bits 0/2 low
        {5'h04, 32'h0000_0005, 32'h0000_0005},  // R10 enable
        {5'h08, 32'hFFFF_FFFF, 32'h0000_0004},  // R1 R10 function
        {5'h08, 32'h0000_0000, 32'h0000_0000},  // R10 function clear
        {5'h00, 32'h0000_0001, 32'h0000_0001},  // R10 data
        {5'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
        {5'h0C, 32'hFFFF_FFFF, 32'h0000_0004}   // R1 R10 input enable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // First reset with strap low.
        pad_in = 2'b00;
        repeat (3) @(negedge clk);
        check("R2 pad_ie0 in reset", 32'(pad_ie[0]), 32'd1);
        check("R2 pad_pu0 in reset", 32'(pad_pu[0]), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 boot low", 32'(boot_mode), 32'd0);
        check("R4 pad_oe", 32'(pad_oe), 32'd0);
        check("R4 pad_ie", 32'(pad_ie), 32'd0);
        check("R4 pad_pu", 32'(pad_pu), 32'd1);
        check("R4 pad_out", 32'(pad_out), 32'd0);
        read_check("R4 data reg", 5'h00, 32'd0);
        pad_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 boot holds", 32'(boot_mode), 32'd0);
        pad_in[0] = 1'b0;

        // Table walk: write, then read back.
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][68:64], VEC[i][63:32]);
            read_check($sformatf("R1/R10 vector %0d", i), VEC[i][68:64], VEC[i][31:0]);
        end

        // State now: data=1, enable=5, function=0, input enable=1, pin2=0.
        @(negedge clk);
        check("R5 pad_out", 32'(pad_out), 32'd1);
        check("R5 pad_oe", 32'(pad_oe), 32'd3);
        check("R7 irq idle", 32'(irq_out), 32'd0);

        pad_in[1] = 1'b1;
        @(negedge clk);
        read_check("R6 one edge", 5'h00, 32'd1);
        @(negedge clk);
        read_check("R6 two edges", 5'h00, 32'd5);
        check("R7 irq run, port function", 32'(irq_out), 32'd1);

        stop_mode = 1'b1; stop_drive = 1'b1;
        #1;
        check("R8 irq stop, port function", 32'(irq_out), 32'd0);
        check("R9 drive forced off", 32'(pad_oe), 32'd0);
        bus_write(5'h08, 32'h4);
        #1;
        check("R8 irq stop, interrupt function", 32'(irq_out), 32'd1);
        check("R9 drive kept with interrupt", 32'(pad_oe), 32'd3);
        stop_drive = 1'b0;
        bus_write(5'h08, 32'h0);
        #1;
        check("R9 stop without drive-off", 32'(pad_oe), 32'd3);
        check("R8 irq stop no drive-off", 32'(irq_out), 32'd0);
        stop_mode = 1'b0;

        bus_write(5'h0C, 32'h0);
        #1;
        check("R7 irq input disabled", 32'(irq_out), 32'd0);
        read_check("R6 latch readback", 5'h00, 32'd1);
        check("R3 boot still held", 32'(boot_mode), 32'd0);

        // Second reset with strap high.
        @(negedge clk);
        rst_n = 1'b0; pad_in = 2'b01;
        repeat (2) @(negedge clk);
        check("R2 pad_ie0 second reset", 32'(pad_ie[0]), 32'd1);
        rst_n = 1'b1; pad_in[0] = 1'b0;
        @(negedge clk);
        check("R3 boot high", 32'(boot_mode), 32'd1);
        read_check("R4 enable cleared", 5'h04, 32'd0);
        read_check("R4 input enable cleared", 5'h0C, 32'd0);
        check("R4 pad_oe second", 32'(pad_oe), 32'd0);
        repeat (2) @(negedge clk);
        check("R3 boot holds high", 32'(boot_mode), 32'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule